// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises one interrupt line toward a processor. The processor answers with a one-cycle acknowledge pulse and receives an 8-bit vector in the same cycle. Software sets the block up and services it through a small register port: a chip select, one address bit, write and read strobes, and 8-bit data buses. What a written byte means depends on the address and on its position in the command stream.

After reset the block is idle, with every input masked. Software writes a start command to the even address. It then writes a short run of configuration bytes to the odd address. From that point the odd address holds the mask register and the even address takes control commands: end-of-interrupt, read-source selection and poll. An acknowledge that arrives while nothing can be granted returns the lowest-priority level and leaves the in-service state alone, so software can tell that the interrupt was spurious.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_out is low and a read of the odd address returns 0xFF (all inputs masked).
- R2: An even-address write with bit 4 set starts initialization. It clears the mask and in-service registers, makes the request register the even-address read source, and holds int_out low. Bit 1 set means no cascade word follows and bit 0 set means a mode word follows. The next odd-address writes are taken in order: the vector base (bits 7:3 kept), the cascade word unless skipped, and the mode word if requested. The block is then ready.
- R3: When the block is ready, odd-address writes and reads access the mask register. A set mask bit keeps the matching input from being granted while its request stays pending.
- R4: A request bit is set on a rising edge of its input and cleared if the input falls before acknowledge. An input that stays high after acknowledge does not request again.
- R5: Priority is fixed with input 0 highest. The highest-priority pending unmasked request is granted, and int_out is raised, only if no in-service bit at that level or a higher-priority level is set.
- R6: An acknowledge pulse on inta with a grant returns vec = {base[7:3], level}, sets that level's in-service bit and clears its request bit.
- R7: An acknowledge with no grant returns level 7 in vec[2:0] and leaves the in-service register unchanged.
- R8: Writing 0x20 to the even address clears the lowest-numbered set in-service bit. Other end-of-interrupt codes (bits 4:3 = 00 with bits 7:5 other than 001), such as 0x60, change nothing.
- R9: An even-address write with bit 4 clear and bit 3 set is a read control. Bits 1:0 = 11 select the in-service register, 10 select the request register, 01 select the stored cascade word, and 00 keep the current choice. The choice stays in effect across later reads.
- R10: A read control with bit 2 set (for example 0x0C) arms a poll. The next even-address read returns bit 7 = grant present, bits 6:3 = 0 and bits 2:0 = level (7 if none), and acknowledges a granted level as in R6. The poll then disarms and the earlier read selection applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register port select |
| a0 | input | 1 | Register address: 0 even, 1 odd |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, valid during the read strobe |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle |
| vec | output | 8 | Vector, valid during inta |

## Verification
The hardest state to reach from the ports is the spurious acknowledge. It needs a request that was latched, and so briefly raised int_out, but was withdrawn before the acknowledge arrived. The stimulus raises input 6, drops it two cycles later, and then sends inta. It checks for vector level 7 and reads the in-service and request registers back through the read-control command. Nested service is reached in a similar way: a higher-priority input is raised while a lower level is in service, and in the reverse case a lower-priority request must stay blocked until an end-of-interrupt.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } init_st_e;

    typedef enum logic [1:0] {
        RS_REQ,
        RS_SVC,
        RS_CASC
    } rsel_e;

    typedef struct packed {
        logic init_start;
        logic cfg_word;
        logic mask_wr;
        logic eoi;
        logic rd_ctl;
    } wcmd_t;

endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_pkg::*;
(
    input  logic       sel,
    input  logic       wr_stb,
    input  logic       addr,
    input  logic [7:3] din_hi,
    input  init_st_e   st,
    output wcmd_t      cmd
);

    logic wr_en;
    logic is_ready;
    logic in_cfg;

    always_comb begin
        wr_en    = sel & wr_stb;
        is_ready = (st == ST_READY);
        in_cfg   = (st == ST_BASE) || (st == ST_CASC) || (st == ST_MODE);

        cmd.init_start = wr_en & ~addr & din_hi[4];
        cmd.cfg_word   = wr_en & addr & in_cfg;
        cmd.mask_wr    = wr_en & addr & is_ready;
        cmd.eoi        = wr_en & ~addr & ~din_hi[4] & ~din_hi[3] & is_ready
                         & (din_hi[7:5] == 3'b001);
        cmd.rd_ctl     = wr_en & ~addr & ~din_hi[4] & din_hi[3] & is_ready;
    end

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d.prev = req_in;
        lat_d.pend = (lat_q.pend | (req_in & ~lat_q.prev)) & req_in & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign pend = lat_q.pend;

    // R4
    pend_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q.pend & ~lat_q.prev) == '0);

endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  svc,
    output logic          hit,
    output logic [LW-1:0] lvl
);

    logic [N-1:0] elig;
    logic [N-1:0] first;
    logic         seen_any;
    logic         svc_seen;
    logic         blocked;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_elig
            assign elig[g] = pend[g] & ~mask[g];
        end
    endgenerate

    always_comb begin
        seen_any = 1'b0;
        svc_seen = 1'b0;
        blocked  = 1'b0;
        first    = '0;
        for (int i = 0; i < N; i++) begin
            svc_seen = svc_seen | svc[i];
            if (elig[i] && !seen_any) begin
                first[i] = 1'b1;
                blocked  = svc_seen;
            end
            seen_any = seen_any | elig[i];
        end
    end

    always_comb begin
        lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) lvl = LW'(i);
        end
    end

    assign hit = (|first) & ~blocked;

    logic [N-1:0] chk_upto;
    logic [N-1:0] chk_above;
    always_comb begin
        for (int i = 0; i < N; i++) begin
            chk_upto[i]  = (i <= int'(lvl));
            chk_above[i] = (i < int'(lvl));
        end
    end

    // R5
    grant_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend[lvl] && !mask[lvl] && ((svc & chk_upto) == '0)
                 && ((pend & ~mask & chk_above) == '0)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              a0,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [N_REQ-1:0]  irq_in,
    output logic              int_out,
    input  logic              inta,
    output logic [DATA_W-1:0] vec
);

    localparam int LVL_W  = $clog2(N_REQ);
    localparam int BASE_W = DATA_W - LVL_W;
    localparam int PAD_W  = DATA_W - 1 - LVL_W;

    typedef struct packed {
        init_st_e          st;
        logic [N_REQ-1:0]  imr;
        logic [N_REQ-1:0]  isr;
        logic [BASE_W-1:0] vbase;
        logic [DATA_W-1:0] casc;
        logic              single;
        logic              need4;
        rsel_e             rsel;
        logic              poll_arm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    wcmd_t             cmd;
    logic [N_REQ-1:0]  irr;
    logic [N_REQ-1:0]  ack_clr;
    logic [N_REQ-1:0]  eoi_hot;
    logic [N_REQ-1:0]  lvl_hot;
    logic              hit;
    logic [LVL_W-1:0]  lvl;
    logic              ready;
    logic              grant;
    logic              poll_rd;
    logic              ack_take;
    logic [LVL_W-1:0]  ack_lvl;
    logic              eoi_found;

    pic_cmd_dec u_dec (
        .sel    (cs),
        .wr_stb (wr),
        .addr   (a0),
        .din_hi (din[7:3]),
        .st     (ctl_q.st),
        .cmd    (cmd)
    );

    pic_req_latch #(.N(N_REQ)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (irq_in),
        .clr    (ack_clr),
        .pend   (irr)
    );

    pic_prio_res #(.N(N_REQ), .LW(LVL_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (irr),
        .mask  (ctl_q.imr),
        .svc   (ctl_q.isr),
        .hit   (hit),
        .lvl   (lvl)
    );

    always_comb begin
        ready    = (ctl_q.st == ST_READY);
        grant    = hit & ready;
        poll_rd  = cs & rd & ~a0 & ctl_q.poll_arm & ready;
        ack_take = ((inta & ready) | poll_rd) & grant;
        ack_lvl  = grant ? lvl : LVL_W'(N_REQ - 1);
        lvl_hot  = ack_take ? (N_REQ'(1) << lvl) : '0;
        ack_clr  = lvl_hot;
    end

    always_comb begin
        eoi_hot   = '0;
        eoi_found = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (ctl_q.isr[i] && !eoi_found) begin
                eoi_hot[i] = 1'b1;
                eoi_found  = 1'b1;
            end
        end
    end

    assign int_out = grant;
    assign vec     = inta ? {ctl_q.vbase, ack_lvl} : '0;

    always_comb begin
        dout = '0;
        if (cs && rd) begin
            if (a0) begin
                dout[N_REQ-1:0] = ctl_q.imr;
            end else if (ctl_q.poll_arm && ready) begin
                dout = {grant, {PAD_W{1'b0}}, ack_lvl};
            end else begin
                case (ctl_q.rsel)
                    RS_SVC:  dout[N_REQ-1:0] = ctl_q.isr;
                    RS_CASC: dout = ctl_q.casc;
                    default: dout[N_REQ-1:0] = irr;
                endcase
            end
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (cmd.init_start) begin
            ctl_d.st       = ST_BASE;
            ctl_d.imr      = '0;
            ctl_d.isr      = '0;
            ctl_d.rsel     = RS_REQ;
            ctl_d.poll_arm = 1'b0;
            ctl_d.single   = din[1];
            ctl_d.need4    = din[0];
        end else begin
            if (cmd.cfg_word) begin
                case (ctl_q.st)
                    ST_BASE: begin
                        ctl_d.vbase = din[DATA_W-1:LVL_W];
                        if (!ctl_q.single)    ctl_d.st = ST_CASC;
                        else if (ctl_q.need4) ctl_d.st = ST_MODE;
                        else                  ctl_d.st = ST_READY;
                    end
                    ST_CASC: begin
                        ctl_d.casc = din;
                        ctl_d.st   = ctl_q.need4 ? ST_MODE : ST_READY;
                    end
                    default: ctl_d.st = ST_READY;
                endcase
            end
            if (cmd.mask_wr) ctl_d.imr = din[N_REQ-1:0];
            if (cmd.rd_ctl) begin
                if (din[2]) ctl_d.poll_arm = 1'b1;
                case (din[1:0])
                    2'b11:   ctl_d.rsel = RS_SVC;
                    2'b10:   ctl_d.rsel = RS_REQ;
                    2'b01:   ctl_d.rsel = RS_CASC;
                    default: ctl_d.rsel = ctl_q.rsel;
                endcase
            end
            if (poll_rd) ctl_d.poll_arm = 1'b0;
            ctl_d.isr = (ctl_q.isr & ~(cmd.eoi ? eoi_hot : '0)) | lvl_hot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_UNINIT;
            ctl_q.imr      <= '1;
            ctl_q.rsel     <= RS_REQ;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.init_start |=> (ctl_q.imr == '0 && ctl_q.isr == '0 && !int_out));

    // R6
    ack_sets_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !cmd.init_start) |=> ctl_q.isr[$past(lvl)]);

    // R7
    spurious_keeps_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out && !cmd.init_start && !cmd.eoi) |=> ctl_q.isr == $past(ctl_q.isr));

    // R8
    eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.eoi && !ack_take && ctl_q.isr != '0)
        |=> $countones(ctl_q.isr) == $past($countones(ctl_q.isr)) - 1);

    // R10
    poll_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !cmd.rd_ctl && !cmd.init_start) |=> !ctl_q.poll_arm);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, a0 = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] irq_in = '0;
    logic [7:0] dout, vec;
    logic       int_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr), .rd(rd),
        .din(din), .dout(dout), .irq_in(irq_in), .int_out(int_out),
        .inta(inta), .vec(vec)
    );

    localparam int OP_WR = 0, OP_RD = 1, OP_ACK = 2, OP_IRQ = 3, OP_INT = 4;

    function automatic logic [15:0] mk(input int op, input int a, input int d, input int r);
        return {3'(op), 1'(a), 8'(d), 4'(r)};
    endfunction

    localparam int TBL_N = 56;
    localparam logic [15:0] TBL [TBL_N] = '{
        mk(OP_WR, 0, 8'h11, 2),  // R2 start, cascade and mode follow
        mk(OP_WR, 1, 8'h40, 2),  // R2 base
        mk(OP_WR, 1, 8'h04, 2),  // R2 cascade word
        mk(OP_WR, 1, 8'h01, 2),  // R2 mode word
        mk(OP_RD, 1, 8'h00, 3),  // R3 mask cleared by init
        mk(OP_IRQ, 0, 8'h08, 4), // R4 rise input 3
        mk(OP_INT, 0, 8'h01, 5), // R5
        mk(OP_RD, 0, 8'h08, 9),  // R9 request register by default
        mk(OP_ACK, 0, 8'h43, 6), // R6
        mk(OP_INT, 0, 8'h00, 6), // R6 request cleared
        mk(OP_WR, 0, 8'h0B, 9),  // R9 select in-service
        mk(OP_RD, 0, 8'h08, 9),  // R9
        mk(OP_IRQ, 0, 8'h0A, 5), // R5 input 1 rises while 3 in service
        mk(OP_INT, 0, 8'h01, 5), // R5 nesting
        mk(OP_ACK, 0, 8'h41, 5), // R5
        mk(OP_RD, 0, 8'h0A, 6),  // R6
        mk(OP_WR, 0, 8'h60, 8),  // R8 other code ignored
        mk(OP_RD, 0, 8'h0A, 8),  // R8
        mk(OP_WR, 0, 8'h20, 8),  // R8
        mk(OP_RD, 0, 8'h08, 8),  // R8 lowest bit cleared
        mk(OP_WR, 0, 8'h20, 8),  // R8
        mk(OP_RD, 0, 8'h00, 8),  // R8
        mk(OP_INT, 0, 8'h00, 4), // R4 held inputs do not retrigger
        mk(OP_IRQ, 0, 8'h00, 4), // R4
        mk(OP_WR, 1, 8'h10, 3),  // R3 mask input 4
        mk(OP_IRQ, 0, 8'h10, 3), // R3
        mk(OP_INT, 0, 8'h00, 3), // R3 masked
        mk(OP_RD, 1, 8'h10, 3),  // R3
        mk(OP_WR, 1, 8'h00, 3),  // R3 unmask
        mk(OP_INT, 0, 8'h01, 3), // R3 pending survives mask
        mk(OP_ACK, 0, 8'h44, 6), // R6
        mk(OP_IRQ, 0, 8'h20, 5), // R5 input 5 below in-service 4
        mk(OP_INT, 0, 8'h00, 5), // R5 blocked
        mk(OP_WR, 0, 8'h20, 8),  // R8
        mk(OP_INT, 0, 8'h01, 5), // R5
        mk(OP_ACK, 0, 8'h45, 6), // R6
        mk(OP_WR, 0, 8'h20, 8),  // R8
        mk(OP_IRQ, 0, 8'h00, 10),// R10
        mk(OP_IRQ, 0, 8'h04, 10),// R10
        mk(OP_WR, 0, 8'h0C, 10), // R10 arm poll
        mk(OP_RD, 0, 8'h82, 10), // R10 poll byte
        mk(OP_RD, 0, 8'h04, 10), // R10 selection back, level 2 acked
        mk(OP_WR, 0, 8'h20, 8),  // R8
        mk(OP_WR, 0, 8'h0C, 10), // R10
        mk(OP_RD, 0, 8'h07, 10), // R10 nothing pending
        mk(OP_WR, 0, 8'h09, 9),  // R9 select cascade word
        mk(OP_RD, 0, 8'h04, 9),  // R9
        mk(OP_IRQ, 0, 8'h00, 7), // R7
        mk(OP_IRQ, 0, 8'h40, 7), // R7 input 6 rises
        mk(OP_IRQ, 0, 8'h00, 7), // R7 and goes away
        mk(OP_INT, 0, 8'h00, 4), // R4 cleared by fall
        mk(OP_ACK, 0, 8'h47, 7), // R7 spurious level
        mk(OP_WR, 0, 8'h0B, 7),  // R7
        mk(OP_RD, 0, 8'h00, 7),  // R7 in-service untouched
        mk(OP_WR, 0, 8'h0A, 9),  // R9 select request
        mk(OP_RD, 0, 8'h00, 4)   // R4 request empty
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; wr = 1'b1; a0 = a; din = d;
        @(negedge clk); cs = 1'b0; wr = 1'b0; din = '0;
    endtask

    task automatic do_rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk); cs = 1'b1; rd = 1'b1; a0 = a;
        #1 check(tag, dout, exp);
        @(negedge clk); cs = 1'b0; rd = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag);
        @(negedge clk); inta = 1'b1;
        #1 check(tag, vec, exp);
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic do_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic chk_int(input logic exp, input string tag);
        @(negedge clk);
        #1 check(tag, {7'b0, int_out}, {7'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_int(1'b0, "R1");
        do_rd(1'b1, 8'hFF, "R1");
        // R2 nothing granted before initialization
        do_irq(8'h01);
        chk_int(1'b0, "R2");
        do_irq(8'h00);

        for (int i = 0; i < TBL_N; i++) begin
            string tag;
            logic [2:0] op;
            logic       a;
            logic [7:0] d;
            {op, a, d} = TBL[i][15:4];
            tag = $sformatf("R%0d row %0d", TBL[i][3:0], i);
            case (op)
                3'(OP_WR):  do_wr(a, d);
                3'(OP_RD):  do_rd(a, d, tag);
                3'(OP_ACK): do_ack(d, tag);
                3'(OP_IRQ): do_irq(d);
                default:    chk_int(d[0], tag);
            endcase
        end

        // R2 re-init: single, no mode word; clears in-service
        do_irq(8'h01);
        do_ack(8'h40, "R6");
        do_wr(1'b0, 8'h12);
        chk_int(1'b0, "R2");
        do_wr(1'b1, 8'hA8);
        do_wr(1'b1, 8'h55);
        do_rd(1'b1, 8'h55, "R2");
        do_rd(1'b0, 8'h00, "R2");
        do_wr(1'b0, 8'h0B);
        do_rd(1'b0, 8'h00, "R2");
        do_irq(8'h02);
        chk_int(1'b1, "R5");
        do_ack(8'hA9, "R6");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule